// File: doc/BRIEF.md
# Byte-Wide NOR Flash Command Controller

This block models the bus-facing control logic of a byte-wide NOR flash memory. It watches single-cycle write strobes, each with an address and a data byte, for unlock prefixes and command codes. It runs byte program, sector erase and chip erase as timed embedded operations over a small internal byte array. While an operation runs, the ready output is low and array reads return a polled status byte instead of data. Erase can be suspended so that other sectors can be read or programmed, and then resumed. An active-low asynchronous reset aborts any operation and returns the decoder to array read. The array contents are never cleared by that reset.

Reads are strobed with `rd_en` and are registered: `rdata` is valid in the cycle after the strobe. A write strobe takes priority over a read strobe in the same cycle.

The state machine has these states:

- `S_READ`: array read.
- `S_UNL1` and `S_UNL2`: the first and second unlock cycles have been seen.
- `S_PSETUP`: the next write carries the program address and data.
- `S_ESETUP`, `S_EUNL1` and `S_EUNL2`: the erase prefix and its second unlock.
- `S_EWIN`: the sector-collection window.
- `S_ERASE`: the erase sweep.
- `S_SUSP`: erase suspended.
- `S_BYP`: unlock bypass.
- `S_BYP_EXIT`: the first cycle of the bypass exit.
- `S_PROG`: programming.
- `S_FAULT`: a program has timed out.

Its transitions are these:

- Unlock: READ or SUSP to UNL1 to UNL2.
- From UNL2: to PSETUP on A0h; to ESETUP on 80h; to BYP on 20h. The last two are refused while suspended.
- Program: PSETUP to PROG. PROG then goes to FAULT if the program is impossible, or to the home state if it is not.
- Erase prefix: ESETUP to EUNL1 to EUNL2.
- From EUNL2: to EWIN on 30h, or to ERASE on 10h written at 555h.
- Erase: EWIN to ERASE when the window expires. ERASE goes to READ at the end of the sweep, or to SUSP on B0h.
- Resume: SUSP to ERASE on 30h.
- Bypass: BYP to PSETUP on A0h, and BYP to BYP_EXIT on 90h. BYP_EXIT goes to READ on 00h and otherwise back to BYP.
- Fault: FAULT to the home state on F0h.
- Any break: any broken sequence returns to the home state.

The home state is SUSP while an erase is suspended, BYP while bypass is active, and READ otherwise.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: A command is accepted only after AAh written at 555h followed by 55h written at 2AAh. Any write that does not match the expected next cycle returns the decoder to its home state, and the broken sequence changes nothing in the array.
- R2: Byte program is unlock, then A0h at 555h, then one write carrying the target address and data. When the operation completes, the byte reads back as the written data. Programming may only clear bits; see R12.
- R3: `ready` is high after reset and in every non-busy state, including erase suspend. It is low from the cycle after a program data write or erase command until the operation completes.
- R4: Writes issued while a program is running are ignored, and the program completes with its original data.
- R5: A read during programming returns status. Bit 7 is the complement of bit 7 of the data being written, bit 5 is 0, and bit 6 inverts on every successive status read.
- R6: Sector erase is unlock, 80h at 555h, unlock, then 30h at any address in the sector. The sector is taken from address bits [10:8]. During the following window of ERASE_WIN cycles, each further 30h write adds its sector and restarts the window. Status bit 3 reads 0 during the window and 1 once erasing has begun; status bit 7 is 0. All bytes of the selected sectors then read FFh, and other sectors are unchanged.
- R7: Chip erase is unlock, 80h at 555h, unlock, then 10h at 555h. Afterwards every byte reads FFh.
- R8: A write of F0h at any address returns the unlock and erase-setup states to the home state, and ends a timed-out program.
- R9: Unlock bypass is entered with unlock and then 20h at 555h. Each program then needs only A0h, followed by the address and data write. Writing 90h and then 00h leaves bypass, after which a lone A0h no longer starts a program.
- R10: B0h written during the erase sweep suspends it, and `ready` goes high. A read of an unselected sector returns array data. A read of a selected sector returns status with bit 7 = 1, bit 2 inverting on each such read, and bit 6 steady. A 30h write resumes the erase, which then completes.
- R11: During suspend, a full program sequence may program a byte in an unselected sector. When the program completes, the device returns to suspend.
- R12: A program that would need to change a 0 bit to 1 leaves the array unchanged. After PROG_CYC cycles it reports status bit 5 = 1 and keeps `ready` low until F0h is written.
- R13: Asserting `rst_n` low aborts any program or erase at once, returns the device to array read with `ready` high, and leaves array bytes not yet written unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W | Byte address for the read or write |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Registered read data or status byte |
| ready | output | 1 | High when no embedded operation is running |

## Verification
The bench breaks unlock sequences with a wrong address or a wrong data byte, and with a stray F0h. A decoder that did not fall back to home would then program bytes from the writes that follow.

It programs a byte that needs a 0-to-1 change. A design that silently ANDed the data would return ready and alter the array, where it should report bit 5 and hold ready low.

During suspend, it reads both a selected and an unselected sector, and it programs another sector. A design that lost the sweep position, or that returned to plain read after that program, would show the wrong data or the wrong status.

Finally, it pulses reset in the middle of a program and in the middle of an erase. An abort that committed a partial operation would show up in the array bytes read back afterwards.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        S_READ,
        S_UNL1,
        S_UNL2,
        S_PSETUP,
        S_ESETUP,
        S_EUNL1,
        S_EUNL2,
        S_EWIN,
        S_ERASE,
        S_SUSP,
        S_BYP,
        S_BYP_EXIT,
        S_PROG,
        S_FAULT
    } state_t;

    localparam logic [7:0] CMD_KEY1    = 8'hAA;
    localparam logic [7:0] CMD_KEY2    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM = 8'hA0;
    localparam logic [7:0] CMD_ERASE   = 8'h80;
    localparam logic [7:0] CMD_BYPASS  = 8'h20;
    localparam logic [7:0] CMD_SECTOR  = 8'h30;
    localparam logic [7:0] CMD_CHIP    = 8'h10;
    localparam logic [7:0] CMD_RESET   = 8'hF0;
    localparam logic [7:0] CMD_SUSPEND = 8'hB0;
    localparam logic [7:0] CMD_BYP_X1  = 8'h90;
    localparam logic [7:0] CMD_BYP_X2  = 8'h00;

    localparam logic [10:0] KEY1_ADDR  = 11'h555;
    localparam logic [10:0] KEY2_ADDR  = 11'h2AA;

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign zero = (cnt_q == '0);

    // R3: a running timer counts down by one each cycle, fixing how long ready stays low
    p_timer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && !zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl #(
    parameter int ADDR_W    = 11,
    parameter int SECT_W    = 3,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_WIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              ready
);
    import nor_cmd_pkg::*;

    localparam int NSECT    = 1 << SECT_W;
    localparam int TMAX     = (PROG_CYC > ERASE_WIN) ? PROG_CYC : ERASE_WIN;
    localparam int CNT_W    = $clog2(TMAX + 1);
    localparam logic [ADDR_W-1:0] A_KEY1   = ADDR_W'(KEY1_ADDR);
    localparam logic [ADDR_W-1:0] A_KEY2   = ADDR_W'(KEY2_ADDR);
    localparam logic [ADDR_W-1:0] PTR_LAST = '1;
    localparam logic [CNT_W-1:0]  T_PROG   = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0]  T_WIN    = CNT_W'(ERASE_WIN - 1);

    state_t             state_q, state_nx, home;
    logic               byp_q, susp_q;
    logic [ADDR_W-1:0]  pa_q, ptr_q;
    logic [7:0]         pd_q, rdata_q;
    logic [NSECT-1:0]   sel_q, sect_onehot;
    logic               tog6_q, tog2_q;
    logic [SECT_W-1:0]  addr_sect, ptr_sect;

    logic               key1_hit, key2_hit, is_write30, is_suspend;
    logic               tmr_load, tmr_run, tmr_zero;
    logic [CNT_W-1:0]   tmr_val;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr;
    logic [7:0]         mem_wd, mem_rd_a, mem_rd_b;
    logic               prog_fail, busy_prog, busy_erase, susp_hit;
    logic [7:0]         rd_mux;

    assign addr_sect   = addr[ADDR_W-1 -: SECT_W];
    assign ptr_sect    = ptr_q[ADDR_W-1 -: SECT_W];
    assign sect_onehot = NSECT'(1) << addr_sect;
    assign key1_hit    = wr_en && (wdata == CMD_KEY1) && (addr == A_KEY1);
    assign key2_hit    = wr_en && (wdata == CMD_KEY2) && (addr == A_KEY2);
    assign is_write30  = wr_en && (wdata == CMD_SECTOR);
    assign is_suspend  = wr_en && (wdata == CMD_SUSPEND);
    assign prog_fail   = |(pd_q & ~mem_rd_b);
    assign home        = susp_q ? S_SUSP : (byp_q ? S_BYP : S_READ);

    nor_op_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (tmr_run),
        .zero     (tmr_zero)
    );

    nor_byte_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wd),
        .raddr_a (addr),
        .rdata_a (mem_rd_a),
        .raddr_b (pa_q),
        .rdata_b (mem_rd_b)
    );

    // Next-state decode
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_READ:     if (key1_hit) state_nx = S_UNL1;
            S_SUSP: begin
                if (key1_hit)        state_nx = S_UNL1;
                else if (is_write30) state_nx = S_ERASE;
            end
            S_BYP: begin
                if (wr_en && wdata == CMD_PROGRAM)     state_nx = S_PSETUP;
                else if (wr_en && wdata == CMD_BYP_X1) state_nx = S_BYP_EXIT;
            end
            S_BYP_EXIT: if (wr_en) state_nx = (wdata == CMD_BYP_X2) ? S_READ : S_BYP;
            S_UNL1:     if (wr_en) state_nx = key2_hit ? S_UNL2 : home;
            S_UNL2: begin
                if (wr_en) begin
                    state_nx = home;
                    if (addr == A_KEY1) begin
                        if (wdata == CMD_PROGRAM)                 state_nx = S_PSETUP;
                        else if (wdata == CMD_ERASE && !susp_q)   state_nx = S_ESETUP;
                        else if (wdata == CMD_BYPASS && !susp_q)  state_nx = S_BYP;
                    end
                end
            end
            S_PSETUP:   if (wr_en) state_nx = S_PROG;
            S_ESETUP:   if (wr_en) state_nx = key1_hit ? S_EUNL1 : home;
            S_EUNL1:    if (wr_en) state_nx = key2_hit ? S_EUNL2 : home;
            S_EUNL2: begin
                if (wr_en) begin
                    if (wdata == CMD_SECTOR)                         state_nx = S_EWIN;
                    else if (wdata == CMD_CHIP && addr == A_KEY1)    state_nx = S_ERASE;
                    else                                             state_nx = home;
                end
            end
            S_EWIN:     if (!is_write30 && tmr_zero) state_nx = S_ERASE;
            S_ERASE: begin
                if (is_suspend)              state_nx = S_SUSP;
                else if (ptr_q == PTR_LAST)  state_nx = S_READ;
            end
            S_PROG:     if (tmr_zero) state_nx = prog_fail ? S_FAULT : home;
            S_FAULT:    if (wr_en && wdata == CMD_RESET) state_nx = home;
            default:    state_nx = S_READ;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_READ;
            byp_q   <= 1'b0;
            susp_q  <= 1'b0;
            pa_q    <= '0;
            pd_q    <= '0;
            sel_q   <= '0;
            ptr_q   <= '0;
            tog6_q  <= 1'b0;
            tog2_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == S_UNL2 && state_nx == S_BYP)      byp_q  <= 1'b1;
            if (state_q == S_BYP_EXIT && state_nx == S_READ) byp_q  <= 1'b0;
            if (state_q == S_ERASE && state_nx == S_SUSP)    susp_q <= 1'b1;
            if (state_q == S_SUSP && state_nx == S_ERASE)    susp_q <= 1'b0;
            if (state_q == S_PSETUP && wr_en) begin
                pa_q <= addr;
                pd_q <= wdata;
            end
            if (state_q == S_EUNL2 && state_nx == S_EWIN)       sel_q <= sect_onehot;
            else if (state_q == S_EUNL2 && state_nx == S_ERASE) sel_q <= '1;
            else if (state_q == S_EWIN && is_write30)           sel_q <= sel_q | sect_onehot;
            if (state_nx == S_ERASE && (state_q == S_EWIN || state_q == S_EUNL2))
                ptr_q <= '0;
            else if (state_q == S_ERASE && state_nx == S_ERASE)
                ptr_q <= ptr_q + ADDR_W'(1);
            if (rd_en && !wr_en) begin
                rdata_q <= rd_mux;
                if (busy_prog || busy_erase) tog6_q <= ~tog6_q;
                if (busy_erase || (!busy_prog && susp_hit)) tog2_q <= ~tog2_q;
            end
        end
    end

    // Outputs, timer and array controls, read mux
    always_comb begin
        busy_prog  = (state_q == S_PROG) || (state_q == S_FAULT);
        busy_erase = (state_q == S_EWIN) || (state_q == S_ERASE);
        ready      = !(busy_prog || busy_erase);
        susp_hit   = susp_q && sel_q[addr_sect];

        tmr_run  = (state_q == S_PROG) || (state_q == S_EWIN);
        tmr_load = 1'b0;
        tmr_val  = T_WIN;
        if (state_q == S_PSETUP && wr_en) begin
            tmr_load = 1'b1;
            tmr_val  = T_PROG;
        end else if ((state_q == S_EUNL2 && state_nx == S_EWIN) ||
                     (state_q == S_EWIN && is_write30)) begin
            tmr_load = 1'b1;
        end

        mem_we    = 1'b0;
        mem_waddr = ptr_q;
        mem_wd    = 8'hFF;
        if (state_q == S_PROG) begin
            mem_waddr = pa_q;
            mem_wd    = pd_q;
            mem_we    = tmr_zero && !prog_fail;
        end else if (state_q == S_ERASE && !is_suspend) begin
            mem_we    = sel_q[ptr_sect];
        end

        if (busy_prog)
            rd_mux = {~pd_q[7], tog6_q, (state_q == S_FAULT), 5'b0};
        else if (busy_erase)
            rd_mux = {1'b0, tog6_q, 2'b0, (state_q == S_ERASE), tog2_q, 2'b0};
        else if (susp_hit)
            rd_mux = {1'b1, tog6_q, 3'b0, tog2_q, 2'b0};
        else
            rd_mux = mem_rd_a;
    end

    assign rdata = rdata_q;

    // R3: the cycle after the program data write, the device reports busy
    p_prog_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PSETUP && wr_en) |=> !ready);

    // R4: until its timer expires, programming is not left whatever is written
    p_prog_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROG && !tmr_zero) |=> (state_q == S_PROG));

    // R2: an array update from programming never raises a bit
    p_clear_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PROG && mem_we) |-> ((mem_wd & ~mem_rd_b) == 8'h00));

    // R5: each status read during programming inverts bit 6 for the next one
    p_status_tog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && state_q == S_PROG) |=> (tog6_q != $past(tog6_q)));

    // R6: an expiring window with no new sector starts the erase sweep
    p_window_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_EWIN && tmr_zero && !is_write30) |=> (state_q == S_ERASE));

    // R10: suspend reports ready and keeps the sweep position
    p_susp_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SUSP) |-> ready);
    p_susp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SUSP) |=> $stable(ptr_q));

endmodule

// File: tb/nor_cmd_ctrl_test.sv
module nor_cmd_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        ready;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    nor_cmd_ctrl uut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .ready (ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Scoreboard queues: expected value, compare mask, bits that must differ
    // from the previous read, bits that must equal it, requirement tag
    logic [7:0] exp_q[$];
    logic [7:0] msk_q[$];
    logic [7:0] tgl_q[$];
    logic [7:0] stay_q[$];
    string      tag_q[$];
    logic [7:0] prev_rd = 8'h00;
    logic       rd_d = 1'b0;

    always @(posedge clk) rd_d <= rd_en;

    always @(negedge clk) begin
        if (rd_d && exp_q.size() > 0) begin
            logic [7:0] e, m, t, s;
            string tg;
            e = exp_q.pop_front();
            m = msk_q.pop_front();
            t = tgl_q.pop_front();
            s = stay_q.pop_front();
            tg = tag_q.pop_front();
            n_tests++;
            if (((rdata ^ e) & m) != 8'h00 || ((rdata ^ prev_rd) & t) != t ||
                ((rdata ^ prev_rd) & s) != 8'h00) begin
                n_fail++;
                $display("FAIL %s: read %02h expected %02h mask %02h (previous %02h)",
                         tg, rdata, e, m, prev_rd);
            end
            prev_rd = rdata;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, input logic [7:0] e, input logic [7:0] m,
                      input logic [7:0] t, input logic [7:0] s, input string tag);
        exp_q.push_back(e); msk_q.push_back(m); tgl_q.push_back(t);
        stay_q.push_back(s); tag_q.push_back(tag);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_data(input logic [10:0] a, input logic [7:0] e, input string tag);
        rd(a, e, 8'hFF, 8'h00, 8'h00, tag);
    endtask

    task automatic unl();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
    endtask

    task automatic prog(input logic [10:0] a, input logic [7:0] d);
        unl();
        wr(11'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_pre();
        unl();
        wr(11'h555, 8'h80);
        unl();
    endtask

    task automatic wait_ready(input int max, input string tag);
        int i;
        for (i = 0; i < max && !ready; i++) @(negedge clk);
        chk(ready === 1'b1, tag, ready, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready === 1'b1, "R3 ready after reset", ready, 1);

        // R7: chip erase
        erase_pre();
        wr(11'h555, 8'h10);
        chk(ready === 1'b0, "R3 busy during chip erase", ready, 0);
        wait_ready(3000, "R7 chip erase completes");
        rd_data(11'h000, 8'hFF, "R7 byte 000 erased");
        rd_data(11'h3C5, 8'hFF, "R7 byte 3C5 erased");
        rd_data(11'h7FF, 8'hFF, "R7 byte 7FF erased");

        // R2, R4, R5: program with status polling and ignored writes
        prog(11'h100, 8'h5A);
        chk(ready === 1'b0, "R3 busy during program", ready, 0);
        rd(11'h100, 8'h80, 8'hA0, 8'h00, 8'h00, "R5 status bit7 complement");
        rd(11'h100, 8'h80, 8'hA0, 8'h40, 8'h00, "R5 status bit6 toggles");
        wr(11'h100, 8'hF0);
        wr(11'h555, 8'hAA);
        wait_ready(50, "R2 program completes");
        rd_data(11'h100, 8'h5A, "R2 R4 programmed byte");
        prog(11'h100, 8'h48);
        wait_ready(50, "R2 second program completes");
        rd_data(11'h100, 8'h48, "R2 bits cleared");

        // R12: program needing a 0-to-1 change
        prog(11'h100, 8'h01);
        repeat (12) @(negedge clk);
        chk(ready === 1'b0, "R12 ready held low after timeout", ready, 0);
        rd(11'h100, 8'hA0, 8'hA0, 8'h00, 8'h00, "R12 status bit5 set");
        wr(11'h000, 8'hF0);
        chk(ready === 1'b1, "R8 F0 clears fault", ready, 1);
        rd_data(11'h100, 8'h48, "R12 array unchanged");

        // R1: broken sequences
        unl();
        wr(11'h554, 8'hA0);
        wr(11'h100, 8'h00);
        chk(ready === 1'b1, "R1 wrong command address starts nothing", ready, 1);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h12);
        wr(11'h555, 8'hA0);
        wr(11'h100, 8'h00);
        rd_data(11'h100, 8'h48, "R1 broken unlock leaves array");

        // R8: F0 in the middle of a sequence
        wr(11'h555, 8'hAA);
        wr(11'h007, 8'hF0);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hA0);
        wr(11'h100, 8'h00);
        chk(ready === 1'b1, "R8 F0 aborts sequence", ready, 1);
        rd_data(11'h100, 8'h48, "R8 array unchanged after F0");

        // R9: unlock bypass
        unl();
        wr(11'h555, 8'h20);
        wr(11'h000, 8'hA0);
        wr(11'h200, 8'h33);
        chk(ready === 1'b0, "R9 bypass program busy", ready, 0);
        wait_ready(50, "R9 bypass program completes");
        wr(11'h123, 8'hA0);
        wr(11'h201, 8'h11);
        wait_ready(50, "R9 second bypass program completes");
        rd_data(11'h200, 8'h33, "R9 bypass byte 200");
        rd_data(11'h201, 8'h11, "R9 bypass byte 201");
        wr(11'h000, 8'h90);
        wr(11'h000, 8'h00);
        wr(11'h000, 8'hA0);
        wr(11'h202, 8'h00);
        chk(ready === 1'b1, "R9 lone A0 after exit ignored", ready, 1);
        rd_data(11'h202, 8'hFF, "R9 no program after exit");

        // R6: sector erase with an added sector
        prog(11'h400, 8'h77);
        wait_ready(50, "R2 program 400");
        prog(11'h500, 8'h66);
        wait_ready(50, "R2 program 500");
        erase_pre();
        wr(11'h200, 8'h30);
        rd(11'h200, 8'h00, 8'h88, 8'h00, 8'h00, "R6 bit3 low in window");
        wr(11'h400, 8'h30);
        repeat (WIN + 4) @(negedge clk);
        rd(11'h200, 8'h08, 8'h88, 8'h00, 8'h00, "R6 bit3 high after window");
        wait_ready(3000, "R6 sector erase completes");
        rd_data(11'h200, 8'hFF, "R6 sector 2 erased");
        rd_data(11'h201, 8'hFF, "R6 sector 2 second byte erased");
        rd_data(11'h400, 8'hFF, "R6 added sector 4 erased");
        rd_data(11'h500, 8'h66, "R6 sector 5 untouched");
        rd_data(11'h100, 8'h48, "R6 sector 1 untouched");

        // R10, R11: suspend, program elsewhere, resume
        prog(11'h210, 8'h12);
        wait_ready(50, "R2 program 210");
        erase_pre();
        wr(11'h200, 8'h30);
        repeat (WIN + 24) @(negedge clk);
        wr(11'h000, 8'hB0);
        chk(ready === 1'b1, "R10 ready in suspend", ready, 1);
        rd_data(11'h500, 8'h66, "R10 unselected sector reads array");
        rd(11'h210, 8'h80, 8'h80, 8'h00, 8'h00, "R10 selected sector status");
        rd(11'h210, 8'h80, 8'h80, 8'h04, 8'h40, "R10 bit2 toggles bit6 steady");
        prog(11'h501, 8'h5C);
        chk(ready === 1'b0, "R11 program busy in suspend", ready, 0);
        wait_ready(50, "R11 suspend program completes");
        rd_data(11'h501, 8'h5C, "R11 programmed during suspend");
        rd(11'h210, 8'h80, 8'h80, 8'h00, 8'h00, "R11 back in suspend");
        wr(11'h000, 8'h30);
        chk(ready === 1'b0, "R10 resume busy", ready, 0);
        wait_ready(3000, "R10 resumed erase completes");
        rd_data(11'h210, 8'hFF, "R10 resumed erase cleared sector");
        rd_data(11'h501, 8'h5C, "R11 byte kept after resume");

        // R13: hardware reset aborts program and erase
        prog(11'h600, 8'h00);
        chk(ready === 1'b0, "R13 program started", ready, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(ready === 1'b1, "R13 ready after reset abort", ready, 1);
        rd_data(11'h600, 8'hFF, "R13 aborted program left byte");
        erase_pre();
        wr(11'h500, 8'h30);
        repeat (WIN + 20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk(ready === 1'b1, "R13 ready after erase abort", ready, 1);
        rd_data(11'h500, 8'h66, "R13 aborted erase left byte");

        repeat (4) @(negedge clk);
        summary();
    end

endmodule